// File: doc/BRIEF.md
# Multi-width Arithmetic Shift Unit

This block shifts a byte, word or doubleword operand left or right by a variable amount, using arithmetic rules, and produces the shifted value together with carry, zero, overflow and negative flags. It sits in the execute stage of a processor datapath. The issuing logic supplies the operand, which arrives as two 16-bit halves read from an even register pair. It also supplies a 2-bit size code, a direction bit and the count, which comes either from the low bits of a count register or from an immediate field. A one-cycle start strobe launches the operation.

The result and flags are registered and appear one clock after the start strobe, marked by a single-cycle valid pulse. A doubleword result is split back into a low half and a high half for write-back. A separate strobe says that the high half must also be written to the register two above the destination. Between operations the outputs keep their last values.

Top module: `ash_unit`

## Requirements
- R1: The size code selects the operand width. 2'b00 is a byte (bits 7:0 of `opd_lo`), 2'b01 is a word (`opd_lo`), and 2'b10 or 2'b11 is a doubleword (`{opd_hi, opd_lo}`). A byte result appears in `res_lo[7:0]` with `res_lo[15:8]` zero. A word result fills `res_lo`. For both of these, `res_hi` is zero and `hi_wr` is low. A doubleword puts its low half on `res_lo`, its high half on `res_hi`, and raises `hi_wr`.
- R2: With `use_imm` = 0 the count is `cnt_reg[4:0]` (0 to 31) and the upper bits of `cnt_reg` are ignored. With `use_imm` = 1 the count is `cnt_imm[3:0]` for byte and word and `cnt_imm[4:0]` for doubleword.
- R3: A left shift (`shift_right` = 0) moves the operand toward its MSB and fills with zeros, truncated to the width. A count equal to or above the width gives zero.
- R4: A right shift (`shift_right` = 1) moves the operand toward its LSB and fills with copies of the operand's sign bit at the selected width. A count equal to or above the width gives all sign copies.
- R5: On a left shift by a count k with 1 <= k <= width, carry equals operand bit (width - k). Carry is 0 for k = 0 and for k > width.
- R6: On a right shift by a count k with 1 <= k <= width, carry equals operand bit (k - 1). For k > width carry equals the sign bit, and for k = 0 carry is 0.
- R7: On a left shift, overflow is 1 when the sign position holds differing values across the single-bit steps of the shift. Overflow is always 0 on a right shift.
- R8: Zero is 1 exactly when the result at the selected width is zero. Negative equals the result's MSB at that width.
- R9: Result, flags and `hi_wr` update on the clock edge that samples `start` high, and `out_valid` is high for exactly that following cycle. Without `start` the outputs hold their values. Reset clears every output to zero.
- R10: A count of zero returns the operand unchanged, with carry and overflow both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one shift this cycle |
| shift_right | input | 1 | 1 = arithmetic right, 0 = arithmetic left |
| size | input | 2 | Operand width code |
| use_imm | input | 1 | Count source: 1 = immediate field, 0 = count register |
| cnt_reg | input | 16 | Count register value (low 5 bits used) |
| cnt_imm | input | 5 | Immediate count field |
| opd_lo | input | 16 | Operand low half (register n) |
| opd_hi | input | 16 | Operand high half (register n+2), doubleword only |
| out_valid | output | 1 | One-cycle pulse marking a fresh result |
| res_lo | output | 16 | Result low half |
| res_hi | output | 16 | Result high half |
| hi_wr | output | 1 | High half must be written back |
| flag_c | output | 1 | Carry: last bit shifted out |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Overflow (left shift sign change) |
| flag_n | output | 1 | Negative |

## Verification
The bench targets the count boundaries: zero, exactly the width, and beyond the width. A design that indexed carry without clamping would return a stale or wrong bit there, and one that shifted right logically would lose the sign fill. It checks immediate counts with bit 4 set on byte and word operations, where a design that failed to mask would shift by 16 too many. It also checks a sign that flips and flips back within one shift, which a design that compared only the first and last sign would report as no overflow. A size code of 2'b11 and a count register with junk in its upper bits are used to catch a design that decodes too many bits.

// File: rtl/ash_pkg.sv
package ash_pkg;

    localparam int HALF_W = 16;
    localparam int FULL_W = 2 * HALF_W;
    localparam int CNT_W  = 5;
    localparam int NARROW_IMM_W = 4;
    localparam int NUM_LANES = 3;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_DWALT = 2'b11
    } size_e;

    typedef struct packed {
        logic              valid;
        logic              hi_wr;
        logic [HALF_W-1:0] lo;
        logic [HALF_W-1:0] hi;
        logic              c;
        logic              z;
        logic              v;
        logic              n;
    } ash_state_t;

endpackage

// File: rtl/ash_cnt_sel.sv
module ash_cnt_sel #(
    parameter int CNT_W        = 5,
    parameter int NARROW_IMM_W = 4
) (
    input  logic             use_imm,
    input  logic             wide,
    input  logic [CNT_W-1:0] reg_cnt,
    input  logic [CNT_W-1:0] imm_cnt,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] NARROW_MASK = CNT_W'((1 << NARROW_IMM_W) - 1);

    always_comb begin
        if (!use_imm) begin
            cnt = reg_cnt;
        end else if (wide) begin
            cnt = imm_cnt;
        end else begin
            cnt = imm_cnt & NARROW_MASK;
        end
    end

endmodule

// File: rtl/ash_lane.sv
module ash_lane #(
    parameter int W     = 8,
    parameter int CNT_W = 5
) (
    input  logic [W-1:0]     val,
    input  logic [CNT_W-1:0] cnt,
    input  logic             right,
    output logic [W-1:0]     res,
    output logic             c,
    output logic             v
);

    logic signed [W-1:0] sval;
    logic signed [W-1:0] round_trip;
    logic [W-1:0]        probe;
    int                  k;

    always_comb begin
        sval       = $signed(val);
        k          = int'(cnt);
        round_trip = '0;
        probe      = '0;
        res        = '0;
        c          = 1'b0;
        v          = 1'b0;
        if (right) begin
            // sign-filling right shift; large counts saturate to all sign
            res = W'(sval >>> cnt);
            if (k == 0) begin
                c = 1'b0;
            end else if (k > W) begin
                c = val[W-1];
            end else begin
                probe = val >> (k - 1);
                c     = probe[0];
            end
        end else begin
            res = (k >= W) ? '0 : (val << cnt);
            if (k == 0 || k > W) begin
                c = 1'b0;
            end else begin
                probe = val >> (W - k);
                c     = probe[0];
            end
            // overflow: the top k+1 bits are not all equal, or every bit
            // passed through the sign slot on the way to zero
            if (k >= W) begin
                v = |val;
            end else begin
                round_trip = (sval <<< cnt) >>> cnt;
                v          = (round_trip != sval);
            end
        end
    end

endmodule

// File: rtl/ash_unit.sv
module ash_unit
    import ash_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        shift_right,
    input  logic [1:0]  size,
    input  logic        use_imm,
    input  logic [15:0] cnt_reg,
    input  logic [4:0]  cnt_imm,
    input  logic [15:0] opd_lo,
    input  logic [15:0] opd_hi,
    output logic        out_valid,
    output logic [15:0] res_lo,
    output logic [15:0] res_hi,
    output logic        hi_wr,
    output logic        flag_c,
    output logic        flag_z,
    output logic        flag_v,
    output logic        flag_n
);

    logic [CNT_W-1:0]  cnt_eff;
    logic [FULL_W-1:0] opd_full;
    logic [FULL_W-1:0] lane_res [NUM_LANES];
    logic              lane_c   [NUM_LANES];
    logic              lane_v   [NUM_LANES];
    logic              lane_n   [NUM_LANES];
    logic              is_dword;

    ash_state_t st_d, st_q;

    assign opd_full = {opd_hi, opd_lo};
    assign is_dword = size[1];

    ash_cnt_sel #(
        .CNT_W        (CNT_W),
        .NARROW_IMM_W (NARROW_IMM_W)
    ) u_cnt (
        .use_imm (use_imm),
        .wide    (is_dword),
        .reg_cnt (cnt_reg[CNT_W-1:0]),
        .imm_cnt (cnt_imm),
        .cnt     (cnt_eff)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = 8 << g;
        logic [LW-1:0] r;
        logic          lc;
        logic          lv;

        ash_lane #(
            .W     (LW),
            .CNT_W (CNT_W)
        ) u_lane (
            .val   (opd_full[LW-1:0]),
            .cnt   (cnt_eff),
            .right (shift_right),
            .res   (r),
            .c     (lc),
            .v     (lv)
        );

        assign lane_res[g] = FULL_W'(r);
        assign lane_c[g]   = lc;
        assign lane_v[g]   = lv;
        assign lane_n[g]   = r[LW-1];
    end

    always_comb begin
        logic [FULL_W-1:0] r_sel;
        logic              c_sel;
        logic              v_sel;
        logic              n_sel;

        st_d       = st_q;
        st_d.valid = 1'b0;

        unique case (size_e'(size))
            SZ_BYTE: begin
                r_sel = lane_res[0];
                c_sel = lane_c[0];
                v_sel = lane_v[0];
                n_sel = lane_n[0];
            end
            SZ_WORD: begin
                r_sel = lane_res[1];
                c_sel = lane_c[1];
                v_sel = lane_v[1];
                n_sel = lane_n[1];
            end
            default: begin
                r_sel = lane_res[2];
                c_sel = lane_c[2];
                v_sel = lane_v[2];
                n_sel = lane_n[2];
            end
        endcase

        if (start) begin
            st_d.valid = 1'b1;
            st_d.hi_wr = is_dword;
            st_d.lo    = r_sel[HALF_W-1:0];
            st_d.hi    = r_sel[FULL_W-1:HALF_W];
            st_d.c     = c_sel;
            st_d.v     = v_sel;
            st_d.z     = (r_sel == '0);
            st_d.n     = n_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign res_lo    = st_q.lo;
    assign res_hi    = st_q.hi;
    assign hi_wr     = st_q.hi_wr;
    assign flag_c    = st_q.c;
    assign flag_z    = st_q.z;
    assign flag_v    = st_q.v;
    assign flag_n    = st_q.n;

endmodule

// File: rtl/ash_unit_chk.sv
module ash_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        shift_right,
    input logic [1:0]  size,
    input logic        use_imm,
    input logic [15:0] cnt_reg,
    input logic [4:0]  cnt_imm,
    input logic [15:0] opd_lo,
    input logic [15:0] opd_hi,
    input logic        out_valid,
    input logic [15:0] res_lo,
    input logic [15:0] res_hi,
    input logic        hi_wr,
    input logic        flag_c,
    input logic        flag_z,
    input logic        flag_v,
    input logic        flag_n
);

    a_r9_valid_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> out_valid);

    a_r9_valid_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !out_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(res_lo) && $stable(res_hi) && $stable(flag_c)
                    && $stable(flag_z) && $stable(flag_v) && $stable(flag_n)));

    a_r1_hi_only_dword: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !hi_wr) |-> (res_hi == 16'h0000));

    a_r1_hi_wr_size: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (hi_wr == $past(size[1])));

    a_r7_right_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (start && shift_right) |=> !flag_v);

    a_r10_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !use_imm && cnt_reg[4:0] == 5'd0 && size[1])
        |=> (!flag_c && !flag_v && res_lo == $past(opd_lo) && res_hi == $past(opd_hi)));

    a_r8_z_excl_n: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_z) |-> !flag_n);

endmodule

bind ash_unit ash_unit_chk u_chk (.*);

// File: tb/ash_unit_tb_top.sv
module ash_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        shift_right;
    logic [1:0]  size;
    logic        use_imm;
    logic [15:0] cnt_reg;
    logic [4:0]  cnt_imm;
    logic [15:0] opd_lo;
    logic [15:0] opd_hi;
    logic        out_valid;
    logic [15:0] res_lo;
    logic [15:0] res_hi;
    logic        hi_wr;
    logic        flag_c;
    logic        flag_z;
    logic        flag_v;
    logic        flag_n;

    int  n_total = 0;
    int  n_bad   = 0;
    bit  finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ash_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .shift_right (shift_right),
        .size        (size),
        .use_imm     (use_imm),
        .cnt_reg     (cnt_reg),
        .cnt_imm     (cnt_imm),
        .opd_lo      (opd_lo),
        .opd_hi      (opd_hi),
        .out_valid   (out_valid),
        .res_lo      (res_lo),
        .res_hi      (res_hi),
        .hi_wr       (hi_wr),
        .flag_c      (flag_c),
        .flag_z      (flag_z),
        .flag_v      (flag_v),
        .flag_n      (flag_n)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // step-by-step reference built from the requirements
    task automatic model(input logic [31:0] opd, input int w, input int cnt,
                         input bit right, output logic [31:0] r,
                         output bit c, output bit v);
        logic [31:0] mask;
        logic [31:0] x;
        bit          msb;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        x = opd & mask;
        c = 0;
        v = 0;
        for (int i = 0; i < cnt; i++) begin
            msb = x[w-1];
            if (right) begin
                c = x[0];
                x = (x >> 1) | ({31'h0, msb} << (w - 1));
            end else begin
                c = msb;
                x = (x << 1) & mask;
                if (x[w-1] != msb) v = 1;
            end
        end
        r = x;
    endtask

    task automatic run_op(input string req, input bit right, input logic [1:0] sz,
                          input bit imm_sel, input logic [15:0] creg,
                          input logic [4:0] imm, input logic [31:0] opd);
        int          w;
        int          cnt;
        logic [31:0] r;
        bit          c;
        bit          v;
        w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        if (!imm_sel)      cnt = int'(creg[4:0]);
        else if (w == 32)  cnt = int'(imm);
        else               cnt = int'(imm[3:0]);
        model(opd, w, cnt, right, r, c, v);

        @(negedge clk);
        start       = 1'b1;
        shift_right = right;
        size        = sz;
        use_imm     = imm_sel;
        cnt_reg     = creg;
        cnt_imm     = imm;
        opd_lo      = opd[15:0];
        opd_hi      = opd[31:16];
        @(negedge clk);
        start = 1'b0;
        chk(req, "valid (R9)", 32'(out_valid), 32'h1);
        chk(req, "res_lo (R1)", 32'(res_lo), 32'(r[15:0]));
        chk(req, "res_hi (R1)", 32'(res_hi), 32'(r[31:16]));
        chk(req, "hi_wr (R1)", 32'(hi_wr), 32'(w == 32));
        chk(req, "carry (R5/R6)", 32'(flag_c), 32'(c));
        chk(req, "overflow (R7)", 32'(flag_v), 32'(v));
        chk(req, "zero (R8)", 32'(flag_z), 32'(r == 32'h0));
        chk(req, "negative (R8)", 32'(flag_n), 32'(r[w-1]));
        @(negedge clk);
        chk(req, "valid drop (R9)", 32'(out_valid), 32'h0);
    endtask

    task automatic t_reset();
        chk("R9", "reset valid", 32'(out_valid), 32'h0);
        chk("R9", "reset result", {res_hi, res_lo}, 32'h0);
        chk("R9", "reset flags", {28'h0, flag_c, flag_z, flag_v, flag_n}, 32'h0);
        chk("R9", "reset hi_wr", 32'(hi_wr), 32'h0);
    endtask

    task automatic t_byte_left();
        run_op("R3", 1'b0, 2'b00, 1'b0, 16'd1, 5'd0, 32'h0000_0041);
        run_op("R5", 1'b0, 2'b00, 1'b0, 16'd1, 5'd0, 32'h0000_0081);
        run_op("R3", 1'b0, 2'b00, 1'b0, 16'd3, 5'd0, 32'h0000_AB03);
        // sign flips and flips back within one shift
        run_op("R7", 1'b0, 2'b00, 1'b0, 16'd2, 5'd0, 32'h0000_00A0);
        run_op("R7", 1'b0, 2'b00, 1'b0, 16'd2, 5'd0, 32'h0000_00E5);
    endtask

    task automatic t_word_right();
        run_op("R4", 1'b1, 2'b01, 1'b0, 16'd4, 5'd0, 32'h0000_8000);
        run_op("R6", 1'b1, 2'b01, 1'b0, 16'd1, 5'd0, 32'h0000_0003);
        run_op("R4", 1'b1, 2'b01, 1'b0, 16'd7, 5'd0, 32'h1234_7F80);
    endtask

    task automatic t_dword();
        run_op("R1", 1'b0, 2'b10, 1'b0, 16'd1, 5'd0, 32'h8000_0001);
        run_op("R6", 1'b1, 2'b10, 1'b0, 16'd5, 5'd0, 32'hF000_0010);
        run_op("R1", 1'b1, 2'b11, 1'b0, 16'd9, 5'd0, 32'h8765_4321);
        run_op("R5", 1'b0, 2'b10, 1'b0, 16'd31, 5'd0, 32'h0000_0003);
    endtask

    task automatic t_counts();
        run_op("R2", 1'b0, 2'b00, 1'b1, 16'd0, 5'b1_0011, 32'h0000_0011);
        run_op("R2", 1'b1, 2'b01, 1'b1, 16'd0, 5'b1_0010, 32'h0000_C000);
        run_op("R2", 1'b1, 2'b10, 1'b1, 16'd0, 5'd19, 32'h8000_0000);
        run_op("R2", 1'b0, 2'b01, 1'b0, 16'hFFE2, 5'd7, 32'h0000_1234);
    endtask

    task automatic t_big_counts();
        run_op("R3", 1'b0, 2'b00, 1'b0, 16'd12, 5'd0, 32'h0000_00FF);
        run_op("R5", 1'b0, 2'b00, 1'b0, 16'd8, 5'd0, 32'h0000_0001);
        run_op("R4", 1'b1, 2'b01, 1'b0, 16'd20, 5'd0, 32'h0000_8001);
        run_op("R6", 1'b1, 2'b00, 1'b0, 16'd9, 5'd0, 32'h0000_0040);
        run_op("R6", 1'b1, 2'b01, 1'b0, 16'd16, 5'd0, 32'h0000_8000);
    endtask

    task automatic t_zero_count();
        run_op("R10", 1'b0, 2'b00, 1'b0, 16'd0, 5'd0, 32'h0000_0080);
        run_op("R10", 1'b1, 2'b10, 1'b1, 16'd5, 5'd0, 32'hC001_0002);
        run_op("R8", 1'b1, 2'b01, 1'b0, 16'd3, 5'd0, 32'h0000_0007);
    endtask

    task automatic t_hold();
        logic [31:0] r0;
        logic [3:0]  f0;
        run_op("R9", 1'b0, 2'b01, 1'b0, 16'd2, 5'd0, 32'h0000_4321);
        r0 = {res_hi, res_lo};
        f0 = {flag_c, flag_z, flag_v, flag_n};
        opd_lo      = 16'hFFFF;
        opd_hi      = 16'hFFFF;
        shift_right = 1'b1;
        cnt_reg     = 16'd1;
        repeat (3) @(negedge clk);
        chk("R9", "hold result", {res_hi, res_lo}, r0);
        chk("R9", "hold flags", 32'(f0), 32'({flag_c, flag_z, flag_v, flag_n}));
        chk("R9", "hold valid", 32'(out_valid), 32'h0);
    endtask

    initial begin
        rst_n       = 1'b0;
        start       = 1'b0;
        shift_right = 1'b0;
        size        = 2'b00;
        use_imm     = 1'b0;
        cnt_reg     = 16'h0;
        cnt_imm     = 5'h0;
        opd_lo      = 16'h0;
        opd_hi      = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_left();
        t_word_right();
        t_dword();
        t_counts();
        t_big_counts();
        t_zero_count();
        t_hold();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_bad++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

endmodule